// File: doc/BRIEF.md
# Presettable Down Counter with Zero-Detect Carry

This block is a synchronous down counter of eight stages. A parameter selects the encoding: either one binary word that runs from 255 down to 0, or two BCD decades that run from 99 down to 00. The count falls by one on each rising clock edge while the active-low count enable is asserted. On the step after zero the count wraps to its maximum, so a free-running binary counter repeats every 256 clocks and a BCD counter repeats every 100 clocks.

Three active-low controls load the counter. Clear forces the maximum value. The asynchronous preset forces the jam word at once, with no clock needed. The synchronous preset takes in the jam word on the next rising edge. Clear has the highest priority, then the asynchronous preset, then the synchronous preset, then counting.

The active-low zero-detect output is low only while the count is zero and the enable is asserted. This lets it serve as the carry into the enable of a following stage, so counters can be chained into longer ones. The present count is also brought out so that it can be observed.

Top module: `jam_down_counter`

## Requirements
- R1: A high `rst` sampled at a rising edge sets the count to its maximum: 0xFF in binary mode, 0x99 in BCD mode.
- R2: With `ci_n` low and all three presets and clear high, each rising edge lowers the count by exactly one.
- R3: With `ci_n` high and all presets and clear high, the count does not change across rising edges.
- R4: `zd_n` is low exactly when the count is zero and `ci_n` is low. A high `ci_n` holds `zd_n` high even at zero.
- R5: Counting down from zero wraps to the maximum. A free-running binary counter passes through zero once every 256 edges.
- R6: With `spre_n` low, the next rising edge loads `jam_i` whatever the level of `ci_n`. Before that edge the count is unchanged.
- R7: With `apre_n` low, `count_o` equals `jam_i` at once, with no clock edge, and follows changes of `jam_i`.
- R8: With `clr_n` low, `count_o` shows the maximum at once, with no clock edge.
- R9: A forced value that has been held across at least one rising edge remains after `apre_n` or `clr_n` returns high.
- R10: Precedence from highest to lowest is clear, asynchronous preset, synchronous preset, counting.
- R11: In BCD mode, bits [3:0] hold the units digit and bits [7:4] the tens digit. The units digit steps 9 to 0 and then wraps to 9. The tens digit steps only when the units digit wraps. The sequence 00 then 99 closes a 100-edge cycle.
- R12: When `zd_n` of one stage drives `ci_n` of the next, the next stage decrements only on the edge where the first stage steps from zero to its maximum.
- R13: While counting through zero, `zd_n` stays low for one clock period only, because the next edge moves the count off zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter acts on rising edges |
| rst | input | 1 | Synchronous active-high reset to the maximum count |
| ci_n | input | 1 | Active-low count enable and carry in |
| spre_n | input | 1 | Active-low synchronous preset enable |
| apre_n | input | 1 | Active-low asynchronous preset enable |
| clr_n | input | 1 | Active-low clear to the maximum count |
| jam_i | input | WIDTH | Preset data word; binary, or BCD digits in BCD mode |
| zd_n | output | 1 | Active-low zero detect, also the carry out |
| count_o | output | WIDTH | Present count, including any forced value |

## Verification
The assertions assume that every BCD jam word holds digits no greater than nine. They also assume that any low pulse on `apre_n` or `clr_n` spans at least one rising edge whenever the forced value must persist. The stimulus keeps to both: it uses only valid BCD words on the BCD instance, and it releases each asynchronous control only after at least one edge. All inputs change one nanosecond after a rising edge, so each asynchronous override is seen both between edges and across them. In the chained pair, the second stage's enable comes only from the first stage's zero detect.

// File: rtl/jdc_pkg.sv
`timescale 1ns/1ps
package jdc_pkg;

  typedef enum logic {
    ENC_BIN = 1'b0,
    ENC_BCD = 1'b1
  } enc_e;

  // register update chosen at a clock edge
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DEC  = 2'd1,
    ACT_JAM  = 2'd2,
    ACT_TOP  = 2'd3
  } act_e;

  // source of the visible count between edges
  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_JAM = 2'd1,
    SRC_TOP = 2'd2
  } src_e;

  // largest code for a given encoding and width (width up to 32)
  function automatic logic [31:0] top_code(enc_e enc, int width);
    logic [31:0] v;
    v = '0;
    if (enc == ENC_BIN) begin
      for (int i = 0; i < width; i++) v[i] = 1'b1;
    end else begin
      for (int d = 0; d < width / 4; d++) v = v | (32'h9 << (4 * d));
    end
    return v;
  endfunction

endpackage

// File: rtl/jdc_ctrl.sv
`timescale 1ns/1ps
module jdc_ctrl
  import jdc_pkg::*;
(
  input  logic rst,
  input  logic clr_n,
  input  logic apre_n,
  input  logic spre_n,
  input  logic ci_n,
  output act_e act_o,
  output src_e src_o
);

  // edge action, highest priority first (R10)
  always_comb begin
    if (rst || !clr_n)            act_o = ACT_TOP;
    else if (!apre_n || !spre_n)  act_o = ACT_JAM;
    else if (!ci_n)               act_o = ACT_DEC;
    else                          act_o = ACT_HOLD;
  end

  // immediate override of the visible count (R7, R8)
  always_comb begin
    if (!clr_n)       src_o = SRC_TOP;
    else if (!apre_n) src_o = SRC_JAM;
    else              src_o = SRC_REG;
  end

endmodule

// File: rtl/jdc_digit.sv
`timescale 1ns/1ps
module jdc_digit (
  input  logic [3:0] d_i,
  input  logic       b_i,
  output logic [3:0] d_o,
  output logic       b_o
);

  always_comb begin
    if (!b_i) begin
      d_o = d_i;
      b_o = 1'b0;
    end else if (d_i == 4'd0) begin
      d_o = 4'd9;
      b_o = 1'b1;
    end else begin
      d_o = d_i - 4'd1;
      b_o = 1'b0;
    end
  end

  // R11: a valid decimal digit stays a valid decimal digit
  always_comb begin
    if (d_i <= 4'd9) begin
      a_r11_digit_range: assert (d_o <= 4'd9);
    end
  end

endmodule

// File: rtl/jdc_decr.sv
`timescale 1ns/1ps
module jdc_decr
  import jdc_pkg::*;
#(
  parameter int   WIDTH = 8,
  parameter enc_e ENC   = ENC_BIN
) (
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] dec_o,
  output logic             wrap_o
);

  localparam int DIGITS = WIDTH / 4;

  generate
    if (ENC == ENC_BIN) begin : g_bin
      assign dec_o  = val_i - WIDTH'(1);
      assign wrap_o = (val_i == '0);
    end else begin : g_bcd
      logic [DIGITS:0] brw;
      assign brw[0] = 1'b1;
      for (genvar d = 0; d < DIGITS; d++) begin : g_dig
        jdc_digit u_digit (
          .d_i (val_i[4*d +: 4]),
          .b_i (brw[d]),
          .d_o (dec_o[4*d +: 4]),
          .b_o (brw[d+1])
        );
      end
      assign wrap_o = brw[DIGITS];
    end
  endgenerate

endmodule

// File: rtl/jdc_zero.sv
`timescale 1ns/1ps
module jdc_zero #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             ci_n,
  output logic             zd_n
);

  assign zd_n = ~((val_i == '0) & ~ci_n);

endmodule

// File: rtl/jam_down_counter.sv
`timescale 1ns/1ps
module jam_down_counter
  import jdc_pkg::*;
#(
  parameter int   WIDTH = 8,
  parameter enc_e ENC   = ENC_BIN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ci_n,
  input  logic             spre_n,
  input  logic             apre_n,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] jam_i,
  output logic             zd_n,
  output logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] TOP_CODE = WIDTH'(top_code(ENC, WIDTH));

  act_e             act;
  src_e             src;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] dec_val;
  logic [WIDTH-1:0] view;
  logic             wrap;

  jdc_ctrl u_ctrl (
    .rst    (rst),
    .clr_n  (clr_n),
    .apre_n (apre_n),
    .spre_n (spre_n),
    .ci_n   (ci_n),
    .act_o  (act),
    .src_o  (src)
  );

  jdc_decr #(.WIDTH(WIDTH), .ENC(ENC)) u_decr (
    .val_i  (cnt_q),
    .dec_o  (dec_val),
    .wrap_o (wrap)
  );

  // forced values are captured on each edge while held, so they persist
  always_ff @(posedge clk) begin
    case (act)
      ACT_TOP: cnt_q <= TOP_CODE;
      ACT_JAM: cnt_q <= jam_i;
      ACT_DEC: cnt_q <= dec_val;
      default: cnt_q <= cnt_q;
    endcase
  end

  always_comb begin
    case (src)
      SRC_TOP: view = TOP_CODE;
      SRC_JAM: view = jam_i;
      default: view = cnt_q;
    endcase
  end

  assign count_o = view;

  jdc_zero #(.WIDTH(WIDTH)) u_zero (
    .val_i (view),
    .ci_n  (ci_n),
    .zd_n  (zd_n)
  );

  logic idle;
  assign idle = spre_n && apre_n && clr_n;

  a_r1_reset_top: assert property (@(posedge clk)
    rst |=> (!apre_n || count_o == TOP_CODE));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (idle && ci_n) |=> (!clr_n || !apre_n || $stable(count_o)));

  a_r4_enable_blocks_flag: assert property (@(posedge clk) disable iff (rst)
    ci_n |-> zd_n);

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (idle && !ci_n && count_o == '0) |=>
      (!clr_n || !apre_n || (count_o == TOP_CODE && $past(wrap))));

  a_r6_sync_load: assert property (@(posedge clk) disable iff (rst)
    (!spre_n && apre_n && clr_n) |=>
      (!clr_n || !apre_n || count_o == $past(jam_i)));

  a_r7_async_load: assert property (@(posedge clk) disable iff (rst)
    (!apre_n && clr_n) |-> (count_o == jam_i));

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (count_o == TOP_CODE && zd_n));

  a_r13_one_period: assert property (@(posedge clk) disable iff (rst)
    (!zd_n && idle) |=> (!apre_n || zd_n));

  generate
    if (ENC == ENC_BIN) begin : g_chk_bin
      a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (idle && !ci_n) |=>
          (!clr_n || !apre_n || count_o == $past(count_o) - WIDTH'(1)));
    end
  endgenerate

endmodule

// File: tb/test_jam_down_counter.sv
`timescale 1ns/1ps
module test_jam_down_counter;
  import jdc_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       ci_n = 1'b1, spre_n = 1'b1, apre_n = 1'b1, clr_n = 1'b1;
  logic [7:0] jam = 8'h00;
  logic       zd_a;
  logic [7:0] cnt_a;

  logic       spre_h = 1'b1;
  logic [7:0] jam_h = 8'h00;
  logic       zd_h;
  logic [7:0] cnt_h;

  logic       b_ci = 1'b1, b_spre = 1'b1;
  logic [7:0] b_jam = 8'h00;
  logic       b_zd;
  logic [7:0] b_cnt;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  jam_down_counter #(.WIDTH(8), .ENC(ENC_BIN)) i_jam_down_counter (
    .clk(clk), .rst(rst), .ci_n(ci_n), .spre_n(spre_n), .apre_n(apre_n),
    .clr_n(clr_n), .jam_i(jam), .zd_n(zd_a), .count_o(cnt_a));

  jam_down_counter #(.WIDTH(8), .ENC(ENC_BIN)) i_hi (
    .clk(clk), .rst(rst), .ci_n(zd_a), .spre_n(spre_h), .apre_n(1'b1),
    .clr_n(1'b1), .jam_i(jam_h), .zd_n(zd_h), .count_o(cnt_h));

  jam_down_counter #(.WIDTH(8), .ENC(ENC_BCD)) i_bcd (
    .clk(clk), .rst(rst), .ci_n(b_ci), .spre_n(b_spre), .apre_n(1'b1),
    .clr_n(1'b1), .jam_i(b_jam), .zd_n(b_zd), .count_o(b_cnt));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 binary reset value", cnt_a, 8'hFF);
    chk("R1 bcd reset value", b_cnt, 8'h99);
    chk("R4 flag high at max", zd_a, 1'b1);
  endtask

  task automatic t_count();
    ci_n = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk("R2 decrement", cnt_a, 8'hFF - k);
    end
  endtask

  task automatic t_hold();
    ci_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3 hold with enable high", cnt_a, 8'hFA);
    end
    chk("R4 flag high while holding", zd_a, 1'b1);
  endtask

  task automatic t_sync_and_zero();
    int zeros;
    spre_n = 1'b0; jam = 8'h03; #1;
    chk("R6 no load before edge", cnt_a, 8'hFA);
    tick();
    chk("R6 load with enable high", cnt_a, 8'h03);
    ci_n = 1'b0; jam = 8'h07;
    tick();
    chk("R10 sync load beats counting", cnt_a, 8'h07);
    spre_n = 1'b1;
    for (int k = 6; k >= 0; k--) begin
      tick();
      chk("R2 count toward zero", cnt_a, k);
    end
    chk("R4 flag low at zero", zd_a, 1'b0);
    ci_n = 1'b1; #1;
    chk("R4 enable high masks flag", zd_a, 1'b1);
    ci_n = 1'b0; #1;
    tick();
    chk("R5 wrap to max", cnt_a, 8'hFF);
    chk("R13 flag back high after one period", zd_a, 1'b1);
    zeros = 0;
    for (int k = 0; k < 256; k++) begin
      tick();
      if (!zd_a) zeros++;
    end
    chk("R5 full cycle returns to max", cnt_a, 8'hFF);
    chk("R5 one zero per 256 edges", zeros, 1);
  endtask

  task automatic t_async();
    ci_n = 1'b0; apre_n = 1'b0; jam = 8'h5A; #1;
    chk("R7 immediate async load", cnt_a, 8'h5A);
    tick();
    chk("R10 async preset beats counting", cnt_a, 8'h5A);
    jam = 8'h33; #1;
    chk("R7 follows jam word", cnt_a, 8'h33);
    tick();
    apre_n = 1'b1; #1;
    chk("R9 async value persists", cnt_a, 8'h33);
    tick();
    chk("R2 count after async release", cnt_a, 8'h32);
  endtask

  task automatic t_clear();
    clr_n = 1'b0; apre_n = 1'b0; spre_n = 1'b0; jam = 8'h12; #1;
    chk("R8 immediate clear", cnt_a, 8'hFF);
    tick();
    chk("R10 clear beats presets", cnt_a, 8'hFF);
    clr_n = 1'b1; apre_n = 1'b1; spre_n = 1'b1; #1;
    chk("R9 clear value persists", cnt_a, 8'hFF);
    tick();
    chk("R2 count after clear", cnt_a, 8'hFE);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 reset mid run", cnt_a, 8'hFF);
  endtask

  task automatic t_cascade();
    ci_n = 1'b1; spre_n = 1'b0; jam = 8'h02; spre_h = 1'b0; jam_h = 8'h05;
    tick();
    spre_n = 1'b1; spre_h = 1'b1;
    chk("R12 low stage loaded", cnt_a, 8'h02);
    chk("R12 high stage loaded", cnt_h, 8'h05);
    ci_n = 1'b0;
    tick();
    chk("R12 high stage waits", cnt_h, 8'h05);
    tick();
    chk("R12 high stage waits at low zero", cnt_h, 8'h05);
    chk("R12 carry asserted", zd_a, 1'b0);
    tick();
    chk("R12 low stage wrapped", cnt_a, 8'hFF);
    chk("R12 high stage stepped once", cnt_h, 8'h04);
    chk("R12 high flag idle", zd_h, 1'b1);
    ci_n = 1'b1;
  endtask

  task automatic t_bcd();
    int zeros;
    b_spre = 1'b0; b_jam = 8'h10;
    tick();
    b_spre = 1'b1; b_ci = 1'b0;
    tick();
    chk("R11 tens borrow 10 to 09", b_cnt, 8'h09);
    tick();
    chk("R11 units step", b_cnt, 8'h08);
    b_spre = 1'b0; b_jam = 8'h50;
    tick();
    b_spre = 1'b1;
    tick();
    chk("R11 50 to 49", b_cnt, 8'h49);
    b_spre = 1'b0; b_jam = 8'h00;
    tick();
    b_spre = 1'b1; #1;
    chk("R4 bcd flag at zero", b_zd, 1'b0);
    tick();
    chk("R11 00 wraps to 99", b_cnt, 8'h99);
    zeros = 0;
    for (int k = 0; k < 100; k++) begin
      tick();
      if (!b_zd) zeros++;
    end
    chk("R11 100 edge cycle", b_cnt, 8'h99);
    chk("R11 one zero per cycle", zeros, 1);
    b_ci = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    #1;
    t_reset();
    t_count();
    t_hold();
    t_sync_and_zero();
    t_async();
    t_clear();
    t_cascade();
    t_bcd();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule